// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This block adds or subtracts two signed numbers held in sign-magnitude form. Each operand is `W` bits wide: the top bit is the sign (1 means negative) and the lower `W-1` bits hold the magnitude. A single select input asks for either the sum or the difference.

The block does not convert the operands to two's complement. It XORs the two operand signs with the select bit, and that one bit picks the operation done on the magnitudes.

- When the XOR is 0, the magnitudes are added.
- When the XOR is 1, the second magnitude is subtracted from the first through its two's complement. If that subtraction gives no end carry, the difference came out negative, so it is complemented again and the sign is flipped.

The result sign follows from the first operand's sign and the end carry. A zero result is always given a positive sign. An overflow flag reports a magnitude sum that does not fit in `W-1` bits. The default width is 5 bits.

The datapath is combinational. Its result and flag are captured in registers, so each answer appears one clock after its operands.

Top module: `smas_addsub`

## Requirements
- R1: Bit `W-1` of an operand is its sign (1 = negative) and bits `W-2:0` are its magnitude; `sub`=1 asks for `opa - opb` and `sub`=0 for `opa + opb`. When `opa[W-1] ^ opb[W-1] ^ sub` is 0 the magnitudes are added, and when it is 1 they are subtracted.
- R2: On the add path, the result magnitude is the sum of the two magnitudes modulo 2^(W-1), and the result sign is the sign of `opa` (subject to R6).
- R3: On the add path, `ovf` is 1 exactly when the magnitude sum carries out of bit `W-2`.
- R4: On the subtract path, when `|opa| + (2^(W-1) - |opb|)` produces an end carry, the result magnitude is `|opa| - |opb|` and the sign is the sign of `opa` (subject to R6).
- R5: On the subtract path without an end carry, the result magnitude is the two's complement of the raw sum, which equals `|opb| - |opa|`, and the sign is the complement of `opa`'s sign.
- R6: A result whose magnitude is zero always has sign 0. This includes equal magnitudes on the subtract path, sums of two zero operands of either sign, and an overflowing sum that wraps to zero.
- R7: `ovf` is never 1 for an operation that takes the subtract path.
- R8: `res` and `ovf` are registered. They show the result of the operands sampled at the previous rising clock edge, and a synchronous active-high `rst` clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | W | First operand, sign-magnitude |
| opb | input | W | Second operand, sign-magnitude |
| sub | input | 1 | 1 = subtract `opb` from `opa`, 0 = add |
| res | output | W | Registered sign-magnitude result |
| ovf | output | 1 | Registered overflow flag for the add path |

## Verification
On every cycle the assertions check the following against the operands sampled one clock earlier:
- no negative zero ever leaves the block;
- a subtract-path operation never raises overflow;
- a non-overflowing addition never raises the flag;
- an add-path result carries the first operand's sign;
- a difference never exceeds the larger operand magnitude.

The exact magnitudes need the bench. So do the sign flip after re-complementing and the wrap to zero on overflow. The bench runs every operand pair for both operations against an integer model, and a directed test checks that reset clears the outputs.

// File: rtl/smas_pkg.sv
package smas_pkg;

  // Which magnitude operation the sign parity selects.
  typedef enum logic {
    PATH_ADD = 1'b0,
    PATH_SUB = 1'b1
  } smas_path_e;

  // Carry chain structure for the magnitude adder.
  localparam int CARRY_RIPPLE    = 0;
  localparam int CARRY_LOOKAHEAD = 1;

endpackage

// File: rtl/smas_path_sel.sv
module smas_path_sel
  import smas_pkg::*;
(
  input  logic       sign_a,
  input  logic       sign_b,
  input  logic       sub,
  output smas_path_e path
);

  // Three-way parity of the operand signs and the operation.
  logic parity;

  always_comb begin
    parity = sign_a ^ sign_b ^ sub;
    path   = parity ? PATH_SUB : PATH_ADD;
  end

endmodule

// File: rtl/smas_mag_adder.sv
module smas_mag_adder
  import smas_pkg::*;
#(
  parameter int MW          = 4,
  parameter int CARRY_STYLE = CARRY_RIPPLE
) (
  input  logic [MW-1:0] a,
  input  logic [MW-1:0] b,
  input  logic          inv_b,
  output logic [MW-1:0] sum,
  output logic          cout
);

  // Per-bit generate and propagate terms on the conditionally inverted b.
  logic [MW-1:0] bx;
  logic [MW-1:0] gen;
  logic [MW-1:0] prop;
  logic [MW:0]   carry;

  always_comb begin
    bx   = b ^ {MW{inv_b}};
    gen  = a & bx;
    prop = a ^ bx;
  end

  // Subtraction adds one through the carry input.
  assign carry[0] = inv_b;

  generate
    if (CARRY_STYLE == CARRY_LOOKAHEAD) begin : g_cla
      // Each carry is an OR of generate terms masked by the
      // propagate terms above them.
      for (genvar i = 0; i < MW; i++) begin : g_bit
        always_comb begin
          logic acc;
          logic pchain;
          acc    = gen[i];
          pchain = prop[i];
          for (int j = i - 1; j >= 0; j--) begin
            acc    = acc | (pchain & gen[j]);
            pchain = pchain & prop[j];
          end
          carry[i+1] = acc | (pchain & carry[0]);
        end
      end
    end else begin : g_ripple
      // One full-adder cell per bit, with the carry passed along the chain.
      for (genvar i = 0; i < MW; i++) begin : g_bit
        assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
      end
    end
  endgenerate

  assign sum  = prop ^ carry[MW-1:0];
  assign cout = carry[MW];

endmodule

// File: rtl/smas_fixup.sv
module smas_fixup
  import smas_pkg::*;
#(
  parameter int MW = 4
) (
  input  smas_path_e    path,
  input  logic          sign_a,
  input  logic [MW-1:0] raw,
  input  logic          cout,
  output logic [MW-1:0] mag,
  output logic          sign,
  output logic          ovf
);

  localparam logic [MW-1:0] ONE = {{(MW-1){1'b0}}, 1'b1};

  logic [MW-1:0] recomp;
  logic          sign_pre;

  always_comb begin
    // Two's complement of the raw sum, used when the difference is negative.
    recomp = (~raw) + ONE;

    if (path == PATH_ADD) begin
      mag      = raw;
      sign_pre = sign_a;
      ovf      = cout;
    end else if (cout) begin
      mag      = raw;
      sign_pre = sign_a;
      ovf      = 1'b0;
    end else begin
      mag      = recomp;
      sign_pre = ~sign_a;
      ovf      = 1'b0;
    end

    // A zero magnitude always gets the positive sign.
    sign = sign_pre & (|mag);
  end

endmodule

// File: rtl/smas_addsub.sv
module smas_addsub
  import smas_pkg::*;
#(
  parameter int W           = 5,
  parameter int CARRY_STYLE = CARRY_RIPPLE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf
);

  localparam int MW = W - 1;

  smas_path_e    path;
  logic [MW-1:0] raw_sum;
  logic          raw_cout;
  logic [MW-1:0] fix_mag;
  logic          fix_sign;
  logic          fix_ovf;

  smas_path_sel u_sel (
    .sign_a (opa[W-1]),
    .sign_b (opb[W-1]),
    .sub    (sub),
    .path   (path)
  );

  smas_mag_adder #(
    .MW          (MW),
    .CARRY_STYLE (CARRY_STYLE)
  ) u_add (
    .a     (opa[MW-1:0]),
    .b     (opb[MW-1:0]),
    .inv_b (path == PATH_SUB),
    .sum   (raw_sum),
    .cout  (raw_cout)
  );

  smas_fixup #(
    .MW (MW)
  ) u_fix (
    .path   (path),
    .sign_a (opa[W-1]),
    .raw    (raw_sum),
    .cout   (raw_cout),
    .mag    (fix_mag),
    .sign   (fix_sign),
    .ovf    (fix_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      ovf <= 1'b0;
    end else begin
      res <= {fix_sign, fix_mag};
      ovf <= fix_ovf;
    end
  end

endmodule

// File: rtl/smas_addsub_chk.sv
module smas_addsub_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         sub,
  input logic [W-1:0] res,
  input logic         ovf
);

  localparam int MW = W - 1;

  logic          par;
  logic [MW:0]   mag_sum;
  logic [MW-1:0] mag_max;

  always_comb begin
    par     = opa[W-1] ^ opb[W-1] ^ sub;
    mag_sum = {1'b0, opa[MW-1:0]} + {1'b0, opb[MW-1:0]};
    mag_max = (opa[MW-1:0] > opb[MW-1:0]) ? opa[MW-1:0] : opb[MW-1:0];
  end

  // R6: no negative zero ever leaves the block.
  assert_no_neg_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (res[MW-1:0] == '0) |-> !res[W-1]);

  // R7: the subtract path never reports overflow.
  assert_sub_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    par |=> !ovf);

  // R3: a magnitude sum that fits never raises the flag.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (!par && !mag_sum[MW]) |=> !ovf);

  // R2: an add-path result carries the first operand's sign, or is zero.
  assert_add_sign_R2: assert property (@(posedge clk) disable iff (rst)
    !par |=> (res[W-1] == $past(opa[W-1]) || res[MW-1:0] == '0));

  // R4 and R5: a difference never exceeds the larger magnitude.
  assert_sub_bound_R4: assert property (@(posedge clk) disable iff (rst)
    par |=> (res[MW-1:0] <= $past(mag_max)));

endmodule

bind smas_addsub smas_addsub_chk #(.W(W)) u_chk (
  .clk (clk),
  .rst (rst),
  .opa (opa),
  .opb (opb),
  .sub (sub),
  .res (res),
  .ovf (ovf)
);

// File: tb/tb_smas_addsub.sv
module tb_smas_addsub;

  localparam int W        = 5;
  localparam int MW       = W - 1;
  localparam int MAXMAG   = (1 << MW) - 1;
  localparam int CLK_HALF = 5;
  localparam int NVEC     = 10;

  // Directed vectors: opa, opb, sub, expected res, expected ovf.
  localparam logic [W-1:0] VA [NVEC] = '{5'b01001, 5'b10100, 5'b01001, 5'b11001, 5'b01000,
                                         5'b11111, 5'b00101, 5'b10000, 5'b10011, 5'b00111};
  localparam logic [W-1:0] VB [NVEC] = '{5'b00100, 5'b01001, 5'b10100, 5'b10100, 5'b01000,
                                         5'b11111, 5'b00101, 5'b10000, 5'b10011, 5'b01100};
  localparam logic         VS [NVEC] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
                                         1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [W-1:0] VR [NVEC] = '{5'b00101, 5'b00101, 5'b00101, 5'b10101, 5'b00000,
                                         5'b11110, 5'b00000, 5'b00000, 5'b00000, 5'b10101};
  localparam logic         VO [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                         1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         sub = 1'b0;
  logic [W-1:0] res;
  logic         ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #CLK_HALF clk = ~clk;

  smas_addsub #(.W(W)) dut (
    .clk (clk),
    .rst (rst),
    .opa (opa),
    .opb (opb),
    .sub (sub),
    .res (res),
    .ovf (ovf)
  );

  // Integer reference model built from the requirements.
  function automatic void ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic s, output logic [W-1:0] r, output logic o);
    int va, vb, sum, absv, m;
    va   = a[W-1] ? -int'(a[MW-1:0]) : int'(a[MW-1:0]);
    vb   = b[W-1] ? -int'(b[MW-1:0]) : int'(b[MW-1:0]);
    sum  = s ? (va - vb) : (va + vb);
    absv = (sum < 0) ? -sum : sum;
    o    = (absv > MAXMAG);
    m    = absv % (MAXMAG + 1);
    r    = {((m != 0) && (sum < 0)), MW'(m)};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] er, input logic eo);
    n_chk++;
    if (res !== er || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s: opa=%b opb=%b sub=%b res=%b ovf=%b expected res=%b ovf=%b",
               tag, opa, opb, sub, res, ovf, er, eo);
    end
  endtask

  // Inputs change at a falling edge, are captured at the next rising edge,
  // and the outputs are sampled at the falling edge after that.
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    opa = a;
    opb = b;
    sub = s;
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] er;
    logic         eo;

    // R8: reset clears the outputs even with live operands.
    @(negedge clk);
    apply(5'b00111, 5'b00111, 1'b0);
    check("R8 reset", '0, 1'b0);
    rst = 1'b0;

    // Directed table (R1 R2 R3 R4 R5 R6).
    for (int i = 0; i < NVEC; i++) begin
      apply(VA[i], VB[i], VS[i]);
      check($sformatf("R1 vector %0d", i), VR[i], VO[i]);
    end

    // Exhaustive sweep against the model: R2 R3 R4 R5 R6 R7.
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          apply(W'(a), W'(b), s[0]);
          ref_model(W'(a), W'(b), s[0], er, eo);
          check("R2_R5 sweep", er, eo);
        end
      end
    end

    // R6: negative zero on both operands, subtract path.
    apply(5'b10000, 5'b00000, 1'b1);
    check("R6 neg zero minus zero", 5'b00000, 1'b0);

    // R7: the largest difference never overflows.
    apply(5'b01111, 5'b11111, 1'b0);
    check("R7 sub path", 5'b00000, 1'b0);
    apply(5'b00000, 5'b01111, 1'b1);
    check("R5 recomplement", 5'b11111, 1'b0);

    // R8: reset taken in mid-stream clears the registered result.
    apply(5'b01111, 5'b01111, 1'b0);
    check("R3 overflow before reset", 5'b01110, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset", '0, 1'b0);
    rst = 1'b0;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule